// File: doc/BRIEF.md
# SAR Conversion Control Sequencer

This block is the digital control of a successive-approximation converter. It runs on the conversion clock. A high-to-low transition on the active-low start input samples the input and begins a conversion in the same clock edge. The block then raises a busy flag and searches for the code bit by bit, MSB first. It drives a trial code to the external DAC and reads one comparator bit back on each step. At the end it stores the code in a result register and drops busy. A conversion always takes the resolution plus two clock cycles. There is no pipelining, so the stored code always comes from the conversion that finished last.

The result is read through a parallel port that is gated by an active-low chip select and an active-low read strobe. The block gives the pad ring a data word and a drive enable, and the tri-state buffer sits in the pad. While the port is disabled the data word is forced to zero. When auto-sleep is on, the block raises a sleep status at the end of each conversion. The next start clears it.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion starts only when `cnv_n` is sampled high on one rising clock edge and low on the next. Holding `cnv_n` low does not start any further conversion.
- R2: `busy` is high after the clock edge at which the start transition is detected.
- R3: `busy` stays high for exactly RES+2 clock cycles per conversion and then goes low.
- R4: The first trial code is 1 in the MSB and 0 elsewhere. Each step resolves one bit from MSB to LSB, and a bit is kept when `cmp_in` is 1, meaning the input is at or above the trial code. The stored result is the input value in natural binary, from 0 to 2^RES-1.
- R5: The result register changes only at the edge where `busy` falls, so it can be read at once. It keeps the previous code throughout the next conversion.
- R6: A start transition on `cnv_n` while `busy` is high is ignored. The conversion keeps its length and its result.
- R7: `db_oe` is 1 only when `cs_n` and `rd_n` are both 0. In that case `db_out` equals the result; otherwise `db_out` is all zeros.
- R8: With `auto_sleep_en` at 1, `sleeping` goes high at the edge where `busy` falls and stays high until the next accepted start clears it. With `auto_sleep_en` at 0 it stays low.
- R9: After reset, `busy`, `sleeping`, `dac_code` and the result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_n | input | 1 | Active-low convert start; the falling transition triggers |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| auto_sleep_en | input | 1 | Power down after each conversion |
| cs_n | input | 1 | Active-low chip select of the read port |
| rd_n | input | 1 | Active-low read strobe |
| busy | output | 1 | Conversion in progress |
| sleeping | output | 1 | Powered-down status |
| dac_code | output | RES | Trial code to the DAC |
| db_out | output | RES | Read data toward the pad |
| db_oe | output | 1 | Drive enable for the tri-state pad |

## Verification
The bench models the comparator as an ideal comparison of a code against `dac_code`. Several codes are applied, among them all-zeros, all-ones and the two values on either side of mid-scale. A search that keeps a bit on the wrong comparator polarity, or steps in the wrong order, returns the wrong code for these values. The busy window is counted in cycles, so an off-by-one cycle counter shows up as a length other than RES+2. A second falling edge during a conversion exposes a design that restarts instead of ignoring it. A mid-conversion read exposes a result register that is updated per step instead of once. The bench also drives each strobe on its own to catch read gating that uses only one of the two, and it checks `sleeping` on both sides of a start.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  // number of clock cycles busy stays high for one conversion
  function automatic int unsigned conv_cycles(input int unsigned res);
    return res + 2;
  endfunction

  // bit position resolved at a given search step (step 1 resolves the MSB)
  function automatic int unsigned step_bit(input int unsigned res, input int unsigned step);
    return res - step;
  endfunction
endpackage

// File: rtl/sar_edge_det.sv
`timescale 1ns/1ps
module sar_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b1;
    else        sig_q <= sig_n;
  end

  assign fall = sig_q & ~sig_n;
endmodule

// File: rtl/sar_step_ctrl.sv
`timescale 1ns/1ps
module sar_step_ctrl #(
  parameter int unsigned RES = 12,
  localparam int unsigned NCYC = sar_pkg::conv_cycles(RES),
  localparam int unsigned CW = $clog2(NCYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          auto_sleep,
  output logic          busy,
  output logic          start,
  output logic          done,
  output logic          bit_step,
  output logic [CW-1:0] step,
  output logic          sleeping
);
  localparam logic [CW-1:0] LAST = CW'(NCYC - 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(RES);

  assign start    = fall & ~busy;
  assign done     = busy && (step == LAST);
  assign bit_step = busy && (step != '0) && (step <= LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      step     <= '0;
      sleeping <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      step     <= '0;
      sleeping <= 1'b0;
    end else if (done) begin
      busy     <= 1'b0;
      step     <= '0;
      sleeping <= auto_sleep;
    end else if (busy) begin
      step     <= step + CW'(1);
    end
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && step == '0); // R2
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step <= LAST); // R3
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R3
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && busy && !done) |=> busy && step == $past(step) + CW'(1)); // R6
  AST_SLEEP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && auto_sleep) |=> sleeping); // R8
  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sleeping); // R8
endmodule

// File: rtl/sar_search_reg.sv
`timescale 1ns/1ps
module sar_search_reg #(
  parameter int unsigned RES = 12,
  parameter int unsigned CW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           done,
  input  logic           bit_step,
  input  logic [CW-1:0]  step,
  input  logic           cmp_in,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] result
);
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  logic [CW-1:0]  bidx;
  logic [RES-1:0] cur_mask;
  logic [RES-1:0] next_mask;
  logic [RES-1:0] keep_mask;

  assign bidx      = CW'(RES) - step;
  assign cur_mask  = {{(RES-1){1'b0}}, 1'b1} << bidx;
  assign next_mask = cur_mask >> 1;

  // per-bit decision: the bit under test takes the comparator value
  for (genvar i = 0; i < RES; i++) begin : g_keep
    assign keep_mask[i] = cur_mask[i] & cmp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial  <= '0;
      result <= '0;
    end else begin
      if (start)         trial  <= MSB_ONLY;
      else if (bit_step) trial  <= (trial & ~cur_mask) | keep_mask | next_mask;
      if (done)          result <= trial;
    end
  end

  AST_BIT_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_step |=> trial[$past(bidx)] == $past(cmp_in)); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result)); // R5
endmodule

// File: rtl/sar_read_port.sv
`timescale 1ns/1ps
module sar_read_port #(
  parameter int unsigned RES = 12
) (
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic [RES-1:0] result,
  output logic           db_oe,
  output logic [RES-1:0] db_out
);
  assign db_oe = ~cs_n & ~rd_n;

  for (genvar i = 0; i < RES; i++) begin : g_gate
    assign db_out[i] = result[i] & db_oe;
  end
endmodule

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
module sar_conv_seq #(
  parameter int unsigned RES = 12,
  localparam int unsigned CW = $clog2(sar_pkg::conv_cycles(RES))
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnv_n,
  input  logic           cmp_in,
  input  logic           auto_sleep_en,
  input  logic           cs_n,
  input  logic           rd_n,
  output logic           busy,
  output logic           sleeping,
  output logic [RES-1:0] dac_code,
  output logic [RES-1:0] db_out,
  output logic           db_oe
);
  logic           cnv_fall;
  logic           conv_start;
  logic           conv_done;
  logic           bit_step;
  logic [CW-1:0]  step;
  logic [RES-1:0] result;

  sar_edge_det i_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_n (cnv_n),
    .fall  (cnv_fall)
  );

  sar_step_ctrl #(.RES(RES)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall       (cnv_fall),
    .auto_sleep (auto_sleep_en),
    .busy       (busy),
    .start      (conv_start),
    .done       (conv_done),
    .bit_step   (bit_step),
    .step       (step),
    .sleeping   (sleeping)
  );

  sar_search_reg #(.RES(RES), .CW(CW)) i_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (conv_start),
    .done     (conv_done),
    .bit_step (bit_step),
    .step     (step),
    .cmp_in   (cmp_in),
    .trial    (dac_code),
    .result   (result)
  );

  sar_read_port #(.RES(RES)) i_port (
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .result (result),
    .db_oe  (db_oe),
    .db_out (db_out)
  );

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !db_oe |-> db_out == '0); // R7
  AST_HELD_LOW_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cnv_fall) |=> !busy); // R1
endmodule

// File: tb/test_sar_conv_seq.sv
`timescale 1ns/1ps
module test_sar_conv_seq;
  localparam int RES = 12;
  localparam int NV  = 8;
  // {auto_sleep, input code}
  localparam logic [RES:0] VEC [NV] = '{
    {1'b0, 12'h000}, {1'b0, 12'hFFF}, {1'b1, 12'h800}, {1'b0, 12'h7FF},
    {1'b1, 12'h001}, {1'b0, 12'hA5A}, {1'b1, 12'h555}, {1'b0, 12'hAAA}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv_n = 1'b1;
  logic auto_sleep_en = 1'b0;
  logic cs_n = 1'b1;
  logic rd_n = 1'b1;
  logic [RES-1:0] vin = '0;
  logic cmp_in;
  logic busy, sleeping, db_oe;
  logic [RES-1:0] dac_code, db_out;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  // ideal comparator: input at or above trial level
  assign cmp_in = (vin >= dac_code);

  sar_conv_seq #(.RES(RES)) i_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .cmp_in(cmp_in),
    .auto_sleep_en(auto_sleep_en), .cs_n(cs_n), .rd_n(rd_n),
    .busy(busy), .sleeping(sleeping), .dac_code(dac_code),
    .db_out(db_out), .db_oe(db_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start a conversion; retrig>0 pulses cnv_n low again at that busy cycle
  task automatic convert(input logic [RES-1:0] v, input int retrig, output int highs);
    @(negedge clk);
    vin = v;
    cnv_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R2", busy, 1);
    chk(sleeping == 1'b0, "R8", sleeping, 0);
    cnv_n = 1'b1;
    highs = 0;
    while (busy && highs < 100) begin
      highs++;
      cnv_n = (highs == retrig) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    cnv_n = 1'b1;
  endtask

  task automatic read_and_check(input logic [RES-1:0] exp, input string req);
    cs_n = 1'b0;
    rd_n = 1'b0;
    #1;
    chk(db_oe == 1'b1, "R7", db_oe, 1);
    chk(db_out == exp, req, db_out, exp);
    cs_n = 1'b1;
    rd_n = 1'b1;
    #1;
    chk(db_oe == 1'b0 && db_out == '0, "R7", db_out, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy == 0 && sleeping == 0 && dac_code == 0, "R9", {busy, sleeping, dac_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_and_check('0, "R9");

    // table walk: R3, R4, R5, R8
    for (int k = 0; k < NV; k++) begin
      auto_sleep_en = VEC[k][RES];
      convert(VEC[k][RES-1:0], 0, n);
      chk(n == RES + 2, "R3", n, RES + 2);
      chk(sleeping == VEC[k][RES], "R8", sleeping, VEC[k][RES]);
      read_and_check(VEC[k][RES-1:0], "R4");
    end

    // R1: holding cnv_n low does not start another conversion
    auto_sleep_en = 1'b0;
    @(negedge clk);
    cnv_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1", busy, 1);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R1", busy, 0);
    cnv_n = 1'b1;
    @(negedge clk);

    // R6: second falling edge in mid-conversion is ignored
    convert(12'h3C7, 5, n);
    chk(n == RES + 2, "R6", n, RES + 2);
    read_and_check(12'h3C7, "R6");
    @(negedge clk);
    chk(busy == 1'b0, "R6", busy, 0);

    // R5: old result readable during the next conversion
    @(negedge clk);
    vin = 12'h0F0;
    cnv_n = 1'b0;
    repeat (4) @(negedge clk);
    cnv_n = 1'b1;
    chk(busy == 1'b1, "R5", busy, 1);
    read_and_check(12'h3C7, "R5");
    while (busy) @(negedge clk);
    read_and_check(12'h0F0, "R5");

    // R7: a single strobe does not enable the port
    cs_n = 1'b0; rd_n = 1'b1; #1;
    chk(db_oe == 0 && db_out == 0, "R7", db_out, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk(db_oe == 0 && db_out == 0, "R7", db_out, 0);
    rd_n = 1'b1;

    // R8: sleep persists while idle, clears on next start
    auto_sleep_en = 1'b1;
    convert(12'h123, 0, n);
    repeat (4) @(negedge clk);
    chk(sleeping == 1'b1, "R8", sleeping, 1);
    auto_sleep_en = 1'b0;
    convert(12'h321, 0, n);
    chk(sleeping == 1'b0, "R8", sleeping, 0);
    read_and_check(12'h321, "R4");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule